// File: doc/BRIEF.md
# Sectioned Dual-Bus Register File

This block stores the general, stack, program-counter and temporary registers of a processor datapath, each 32 bits wide, split into 16-bit halves that sit in three sections: high, low and data. Every section has a local segment of an address bus and a local segment of a data bus. Two switches per bus, one at the high/low boundary and one at the low/data boundary, either join the adjacent segments into a wider shared bus or keep them apart. With every switch open, six independent 16-bit transfers can happen in one step.

Every upper half lives in the high section. The lower halves of address-class registers (A0..A6, both stack pointers, PC, address temporary, address output buffer) live in the low section. The lower halves of data-class registers (D0..D7, data temporary) live in the data section. A step names, for each of the six segments, a source (a register half or a step-supplied 16-bit literal), a set of target registers, and the switch settings. One driver can load any number of targets at once. The resolved segment values are registered and shown on the outputs one cycle after the step. A caller uses the block by loading registers through literals and reading them by driving them onto a segment.

Top module: `sectioned_regfile`

## Requirements
- R1: After reset every register half, both bus outputs and the conflict flag are zero.
- R2: With both switches of a bus open, each segment carries only its own driver. The output packs segments as high in bits 47:32, low in 31:16 and data in 15:0, and shows a step's values from the next clock edge on.
- R3: A closed switch (join bit 1 = high/low boundary, join bit 0 = low/data boundary) puts the single driver's value on every joined segment, and every target on those segments loads that same value.
- R4: Register codes are D0..D7 = 0..7, A0..A6 = 8..14, active stack pointer = 15, PC = 16, address temporary = 17, data temporary = 18, address output buffer = 19. A source or target naming a register whose half is not placed in that section neither drives nor loads.
- R5: Any register half can drive or load either bus of its section, and the two buses work in the same step, so six transfers can complete at once.
- R6: When both buses target the same register half in one step, the data-bus value is stored.
- R7: With the sign-extend bit of a bus set, its high segment carries 16 copies of bit 15 of its low segment. A high-section driver in that step is a conflict.
- R8: Two or more drivers on one joined group of either bus set the conflict flag after the step, and no register changes in that step.
- R9: A segment with no driver reads zero. Source mode 0 or 3 means no driver, 1 means register, 2 means literal. Register codes 20..31 drive nothing and load nothing.
- R10: Code 15 selects the user stack pointer when the supervisor select is 0 and the supervisor copy when it is 1. The other copy is untouched.
- R11: With step low, no register changes and the outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Performs a transfer step this cycle |
| super_sel | input | 1 | Selects the supervisor stack pointer for code 15 |
| a_join | input | 2 | Address bus switches: bit 1 high/low, bit 0 low/data |
| a_sext | input | 1 | Sign-extend low segment onto high segment, address bus |
| a_src_mode | input | 6 | Source mode per section, 2 bits each, section s at bits 2s+1:2s |
| a_src_reg | input | 15 | Source register code per section, 5 bits each |
| a_lit | input | 48 | Literal per section, 16 bits each |
| a_tgt | input | 60 | Target mask per section, 20 bits each, bit = register code |
| d_join | input | 2 | Data bus switches |
| d_sext | input | 1 | Sign-extend option, data bus |
| d_src_mode | input | 6 | Source mode per section, data bus |
| d_src_reg | input | 15 | Source register code per section, data bus |
| d_lit | input | 48 | Literal per section, data bus |
| d_tgt | input | 60 | Target mask per section, data bus |
| abus_q | output | 48 | Registered address bus segments {high, low, data} |
| dbus_q | output | 48 | Registered data bus segments {high, low, data} |
| conflict_q | output | 1 | Registered driver conflict flag |

Section index 2 is high, 1 is low and 0 is data.

## Verification
The assertions take for granted that the step inputs are steady across the clock edge and that the literal, mode and switch inputs of a step describe that step alone. They also take for granted that reset is held for at least one edge before the first step. The stimulus changes inputs only on the falling edge and clears every field before composing the next step, so no setting carries over. Conflicting steps are issued on purpose but checked only through the flag and later read-backs, since the bus values of a conflicting step are left unspecified.

// File: rtl/srf_pkg.sv
package srf_pkg;
  localparam int SEC_W    = 16;
  localparam int NSEC     = 3;
  localparam int NLOG     = 20;
  localparam int NPHYS    = 21;
  localparam int SELW     = 5;
  localparam int BUS_W    = NSEC * SEC_W;
  localparam int SEC_DATA = 0;
  localparam int SEC_LOW  = 1;
  localparam int SEC_HIGH = 2;
  localparam int SP_CODE  = 15;
  localparam int DT_PHYS  = 19;
  localparam int NDATA    = 8;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_REG  = 2'd1,
    SRC_LIT  = 2'd2,
    SRC_OFF  = 2'd3
  } src_mode_e;

  // logical code -> physical slot; 31 marks "no register"
  function automatic logic [SELW-1:0] phys_of(input logic [SELW-1:0] lg, input logic sup);
    if (lg < SELW'(SP_CODE))      return lg;
    else if (lg == SELW'(SP_CODE)) return sup ? SELW'(SP_CODE + 1) : SELW'(SP_CODE);
    else if (lg < SELW'(NLOG))    return SELW'(lg + SELW'(1));
    else                          return '1;
  endfunction

  function automatic logic placed(input logic [SELW-1:0] ph, input int sec);
    logic data_class;
    if (ph >= SELW'(NPHYS)) return 1'b0;
    data_class = (ph < SELW'(NDATA)) || (ph == SELW'(DT_PHYS));
    if (sec == SEC_HIGH) return 1'b1;
    if (sec == SEC_DATA) return data_class;
    return !data_class;
  endfunction
endpackage

// File: rtl/srf_section.sv
module srf_section
  import srf_pkg::*;
#(
  parameter int SEC = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             super_sel,
  input  logic [SEC_W-1:0] a_seg,
  input  logic [SEC_W-1:0] d_seg,
  input  logic [NLOG-1:0]  a_tgt,
  input  logic [NLOG-1:0]  d_tgt,
  input  logic [SELW-1:0]  a_sel,
  input  logic [SELW-1:0]  d_sel,
  output logic [SEC_W-1:0] a_rd,
  output logic [SEC_W-1:0] d_rd,
  output logic             a_hit,
  output logic             d_hit
);
  logic [SEC_W-1:0] mem [NPHYS];
  logic [SELW-1:0]  a_ph, d_ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NPHYS; p++) mem[p] <= '0;
    end else if (we) begin
      for (int l = 0; l < NLOG; l++) begin
        if (placed(phys_of(SELW'(l), super_sel), SEC)) begin
          if (d_tgt[l])      mem[phys_of(SELW'(l), super_sel)] <= d_seg;
          else if (a_tgt[l]) mem[phys_of(SELW'(l), super_sel)] <= a_seg;
        end
      end
    end
  end

  always_comb begin
    a_ph  = phys_of(a_sel, super_sel);
    d_ph  = phys_of(d_sel, super_sel);
    a_hit = placed(a_ph, SEC);
    d_hit = placed(d_ph, SEC);
    a_rd  = a_hit ? mem[a_ph] : '0;
    d_rd  = d_hit ? mem[d_ph] : '0;
  end
endmodule

// File: rtl/srf_bus_net.sv
module srf_bus_net
  import srf_pkg::*;
(
  input  logic [NSEC-1:0]  drv,
  input  logic [BUS_W-1:0] val,
  input  logic [1:0]       join_sw,
  input  logic             sext,
  output logic [BUS_W-1:0] seg,
  output logic             conflict
);
  logic             eff_hl;
  logic [1:0]       gid [NSEC];
  logic [NSEC-1:0]  clash;
  logic [BUS_W-1:0] raw;

  always_comb begin
    eff_hl        = join_sw[1] & ~sext;
    gid[SEC_HIGH] = 2'd2;
    gid[SEC_LOW]  = eff_hl ? 2'd2 : 2'd1;
    gid[SEC_DATA] = join_sw[0] ? gid[SEC_LOW] : 2'd0;
  end

  for (genvar i = 0; i < NSEC; i++) begin : g_seg
    logic [1:0]       cnt;
    logic [SEC_W-1:0] acc;
    always_comb begin
      cnt = '0;
      acc = '0;
      for (int j = 0; j < NSEC; j++) begin
        if (drv[j] && gid[j] == gid[i]) begin
          cnt = cnt + 2'd1;
          acc = acc | val[j*SEC_W +: SEC_W];
        end
      end
    end
    assign raw[i*SEC_W +: SEC_W] = (cnt == 2'd1) ? acc : '0;
    assign clash[i]              = (cnt > 2'd1);
  end

  always_comb begin
    seg      = raw;
    conflict = |clash;
    if (sext) begin
      seg[SEC_HIGH*SEC_W +: SEC_W] = {SEC_W{raw[SEC_LOW*SEC_W + SEC_W - 1]}};
      conflict = conflict | drv[SEC_HIGH];
    end
  end
endmodule

// File: rtl/sectioned_regfile.sv
module sectioned_regfile
  import srf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step,
  input  logic                 super_sel,
  input  logic [1:0]           a_join,
  input  logic                 a_sext,
  input  logic [2*NSEC-1:0]    a_src_mode,
  input  logic [SELW*NSEC-1:0] a_src_reg,
  input  logic [BUS_W-1:0]     a_lit,
  input  logic [NLOG*NSEC-1:0] a_tgt,
  input  logic [1:0]           d_join,
  input  logic                 d_sext,
  input  logic [2*NSEC-1:0]    d_src_mode,
  input  logic [SELW*NSEC-1:0] d_src_reg,
  input  logic [BUS_W-1:0]     d_lit,
  input  logic [NLOG*NSEC-1:0] d_tgt,
  output logic [BUS_W-1:0]     abus_q,
  output logic [BUS_W-1:0]     dbus_q,
  output logic                 conflict_q
);
  logic [NSEC-1:0]  a_drv, d_drv;
  logic [BUS_W-1:0] a_val, d_val;
  logic [BUS_W-1:0] a_bus, d_bus;
  logic             a_conf, d_conf, we;

  assign we = step & ~(a_conf | d_conf);

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    logic [SEC_W-1:0] a_rd, d_rd;
    logic             a_hit, d_hit;
    src_mode_e        am, dm;

    assign am = src_mode_e'(a_src_mode[2*s +: 2]);
    assign dm = src_mode_e'(d_src_mode[2*s +: 2]);

    srf_section #(.SEC(s)) u_sec (
      .clk(clk), .rst(rst), .we(we), .super_sel(super_sel),
      .a_seg(a_bus[s*SEC_W +: SEC_W]), .d_seg(d_bus[s*SEC_W +: SEC_W]),
      .a_tgt(a_tgt[s*NLOG +: NLOG]), .d_tgt(d_tgt[s*NLOG +: NLOG]),
      .a_sel(a_src_reg[s*SELW +: SELW]), .d_sel(d_src_reg[s*SELW +: SELW]),
      .a_rd(a_rd), .d_rd(d_rd), .a_hit(a_hit), .d_hit(d_hit)
    );

    assign a_drv[s] = (am == SRC_LIT) || (am == SRC_REG && a_hit);
    assign d_drv[s] = (dm == SRC_LIT) || (dm == SRC_REG && d_hit);
    assign a_val[s*SEC_W +: SEC_W] = (am == SRC_LIT) ? a_lit[s*SEC_W +: SEC_W] : a_rd;
    assign d_val[s*SEC_W +: SEC_W] = (dm == SRC_LIT) ? d_lit[s*SEC_W +: SEC_W] : d_rd;
  end

  srf_bus_net u_abus (
    .drv(a_drv), .val(a_val), .join_sw(a_join), .sext(a_sext),
    .seg(a_bus), .conflict(a_conf)
  );

  srf_bus_net u_dbus (
    .drv(d_drv), .val(d_val), .join_sw(d_join), .sext(d_sext),
    .seg(d_bus), .conflict(d_conf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      abus_q     <= '0;
      dbus_q     <= '0;
      conflict_q <= 1'b0;
    end else if (step) begin
      abus_q     <= a_bus;
      dbus_q     <= d_bus;
      conflict_q <= a_conf | d_conf;
    end
  end
endmodule

// File: rtl/srf_checker.sv
module srf_checker (
  input logic        clk,
  input logic        rst,
  input logic        step,
  input logic [1:0]  a_join,
  input logic        a_sext,
  input logic [5:0]  a_src_mode,
  input logic [47:0] a_lit,
  input logic        d_sext,
  input logic [5:0]  d_src_mode,
  input logic [47:0] abus_q,
  input logic [47:0] dbus_q,
  input logic        conflict_q
);
  p_split_literal_r2: assert property (@(posedge clk) disable iff (rst)
    (step && a_join == 2'b00 && a_src_mode[1:0] == 2'd2) |=> abus_q[15:0] == $past(a_lit[15:0]));

  p_join_broadcast_r3: assert property (@(posedge clk) disable iff (rst)
    (step && a_join == 2'b11 && !a_sext)
      |=> (conflict_q || (abus_q[47:32] == abus_q[31:16] && abus_q[31:16] == abus_q[15:0])));

  p_sext_fill_r7: assert property (@(posedge clk) disable iff (rst)
    (step && a_sext) |=> (conflict_q || abus_q[47:32] == {16{abus_q[31]}}));

  p_two_drivers_r8: assert property (@(posedge clk) disable iff (rst)
    (step && a_join == 2'b11 && a_src_mode[5:4] == 2'd2 && a_src_mode[1:0] == 2'd2) |=> conflict_q);

  p_undriven_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (step && d_src_mode == 6'b0 && !d_sext) |=> dbus_q == 48'h0);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(abus_q) && $stable(dbus_q) && $stable(conflict_q)));
endmodule

bind sectioned_regfile srf_checker u_chk (
  .clk(clk), .rst(rst), .step(step), .a_join(a_join), .a_sext(a_sext),
  .a_src_mode(a_src_mode), .a_lit(a_lit), .d_sext(d_sext), .d_src_mode(d_src_mode),
  .abus_q(abus_q), .dbus_q(dbus_q), .conflict_q(conflict_q)
);

// File: tb/sectioned_regfile_test.sv
`timescale 1ns/1ps
module sectioned_regfile_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step, super_sel, a_sext, d_sext;
  logic [1:0]  a_join, d_join;
  logic [5:0]  a_src_mode, d_src_mode;
  logic [14:0] a_src_reg, d_src_reg;
  logic [47:0] a_lit, d_lit;
  logic [59:0] a_tgt, d_tgt;
  logic [47:0] abus_q, dbus_q;
  logic        conflict_q;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  typedef struct {
    logic [47:0] ea;
    logic [47:0] ed;
    logic        ec;
    bit          chk_bus;
    string       tag;
  } exp_t;
  exp_t sb[$];

  localparam logic [1:0] NONE = 2'd0, REG = 2'd1, LIT = 2'd2;

  always #4 clk = ~clk;

  sectioned_regfile uut (
    .clk(clk), .rst(rst), .step(step), .super_sel(super_sel),
    .a_join(a_join), .a_sext(a_sext), .a_src_mode(a_src_mode), .a_src_reg(a_src_reg),
    .a_lit(a_lit), .a_tgt(a_tgt),
    .d_join(d_join), .d_sext(d_sext), .d_src_mode(d_src_mode), .d_src_reg(d_src_reg),
    .d_lit(d_lit), .d_tgt(d_tgt),
    .abus_q(abus_q), .dbus_q(dbus_q), .conflict_q(conflict_q)
  );

  task automatic check(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_fields();
    step = 0; a_join = 0; d_join = 0; a_sext = 0; d_sext = 0;
    a_src_mode = 0; d_src_mode = 0; a_src_reg = 0; d_src_reg = 0;
    a_lit = 0; d_lit = 0; a_tgt = 0; d_tgt = 0;
  endtask

  task automatic start();
    @(negedge clk);
    clear_fields();
  endtask

  task automatic a_src(input int s, input logic [1:0] m, input logic [4:0] r, input logic [15:0] v);
    a_src_mode[2*s +: 2] = m; a_src_reg[5*s +: 5] = r; a_lit[16*s +: 16] = v;
  endtask
  task automatic d_src(input int s, input logic [1:0] m, input logic [4:0] r, input logic [15:0] v);
    d_src_mode[2*s +: 2] = m; d_src_reg[5*s +: 5] = r; d_lit[16*s +: 16] = v;
  endtask
  task automatic a_to(input int s, input int code); a_tgt[20*s + code] = 1'b1; endtask
  task automatic d_to(input int s, input int code); d_tgt[20*s + code] = 1'b1; endtask

  // driver side of the scoreboard
  task automatic push(input logic [47:0] ea, input logic [47:0] ed, input logic ec,
                      input bit chk_bus, input string tag);
    exp_t e;
    e.ea = ea; e.ed = ed; e.ec = ec; e.chk_bus = chk_bus; e.tag = tag;
    step = 1'b1;
    sb.push_back(e);
  endtask

  // monitor side of the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(conflict_q == e.ec, {e.tag, " conflict"}, {47'b0, conflict_q}, {47'b0, e.ec});
        if (e.chk_bus) begin
          check(abus_q == e.ea, {e.tag, " abus"}, abus_q, e.ea);
          check(dbus_q == e.ed, {e.tag, " dbus"}, dbus_q, e.ed);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    clear_fields();
    super_sel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    check(abus_q == 0 && dbus_q == 0 && !conflict_q, "R1 outputs after reset",
          abus_q ^ dbus_q, 48'h0);

    // R1: registers read zero after reset
    start(); a_src(2, REG, 7, 0); a_src(0, REG, 7, 0); a_src(1, REG, 14, 0);
    push(48'h0, 48'h0, 0, 1, "R1 read D7/A6");

    // R2 R4: split bus write D0, low-section mask bit ignored
    start(); a_src(2, LIT, 0, 16'h1234); a_src(1, LIT, 0, 16'hAAAA); a_src(0, LIT, 0, 16'h5678);
    a_to(2, 0); a_to(1, 0); a_to(0, 0);
    push({16'h1234, 16'hAAAA, 16'h5678}, 48'h0, 0, 1, "R2 write D0");

    // R4: write A0 on data bus, data-section mask bit ignored
    start(); d_src(2, LIT, 0, 16'hCAFE); d_src(1, LIT, 0, 16'h0001); d_src(0, LIT, 0, 16'h5555);
    d_to(2, 8); d_to(1, 8); d_to(0, 8);
    push(48'h0, {16'hCAFE, 16'h0001, 16'h5555}, 0, 1, "R4 write A0");

    // R4 R9: read back, misplaced halves do not drive
    start(); a_src(2, REG, 0, 0); a_src(1, REG, 0, 0); a_src(0, REG, 0, 0);
    d_src(2, REG, 8, 0); d_src(1, REG, 8, 0); d_src(0, REG, 8, 0);
    push({16'h1234, 16'h0000, 16'h5678}, {16'hCAFE, 16'h0001, 16'h0000}, 0, 1, "R4 readback D0/A0");

    // R3: full join broadcast to three targets in three sections
    start(); a_join = 2'b11; a_src(1, REG, 8, 0); a_to(0, 1); a_to(1, 9); a_to(2, 2);
    push({3{16'h0001}}, 48'h0, 0, 1, "R3 broadcast");

    // R3: readback plus partial join on data bus
    start(); a_src(2, REG, 2, 0); a_src(1, REG, 9, 0); a_src(0, REG, 1, 0);
    d_join = 2'b01; d_src(0, REG, 0, 0);
    push({3{16'h0001}}, {16'h0000, 16'h5678, 16'h5678}, 0, 1, "R3 targets loaded and partial join");

    // R5: six independent transfers
    start();
    a_src(2, LIT, 0, 16'h1111); a_to(2, 17);
    a_src(1, LIT, 0, 16'h2222); a_to(1, 17);
    a_src(0, LIT, 0, 16'h3333); a_to(0, 3);
    d_src(2, LIT, 0, 16'h4444); d_to(2, 3);
    d_src(1, LIT, 0, 16'h5555); d_to(1, 16);
    d_src(0, LIT, 0, 16'h6666); d_to(0, 18);
    push({16'h1111, 16'h2222, 16'h3333}, {16'h4444, 16'h5555, 16'h6666}, 0, 1, "R5 six transfers");

    start(); a_src(2, REG, 17, 0); a_src(1, REG, 17, 0); a_src(0, REG, 3, 0);
    d_src(2, REG, 3, 0); d_src(1, REG, 16, 0); d_src(0, REG, 18, 0);
    push({16'h1111, 16'h2222, 16'h3333}, {16'h4444, 16'h5555, 16'h6666}, 0, 1, "R5 six readbacks");

    // R6: both buses target D4 low
    start(); a_src(0, LIT, 0, 16'h0AAA); a_to(0, 4); d_src(0, LIT, 0, 16'h0BBB); d_to(0, 4);
    push({32'h0, 16'h0AAA}, {32'h0, 16'h0BBB}, 0, 1, "R6 dual target");

    // R6 R9: D4 holds data-bus value, invalid code drives nothing
    start(); d_src(0, REG, 4, 0); a_src(0, REG, 25, 0);
    push(48'h0, {32'h0, 16'h0BBB}, 0, 1, "R6 D4 readback / R9 invalid code");

    // R7: sign extension on both buses
    start(); a_sext = 1; a_src(1, LIT, 0, 16'h8001); a_to(2, 19); a_to(1, 19);
    d_sext = 1; d_join = 2'b01; d_src(1, LIT, 0, 16'h7000);
    push({16'hFFFF, 16'h8001, 16'h0000}, {16'h0000, 16'h7000, 16'h7000}, 0, 1, "R7 sign extend");

    start(); a_src(2, REG, 19, 0); a_src(1, REG, 19, 0);
    push({16'hFFFF, 16'h8001, 16'h0000}, 48'h0, 0, 1, "R7 AOB readback");

    // R7 R8: high driver with sign extend is a conflict
    start(); a_sext = 1; a_src(1, LIT, 0, 16'h0001); a_src(2, LIT, 0, 16'h1234);
    a_src(0, LIT, 0, 16'h4321); a_to(0, 5);
    push(48'h0, 48'h0, 1, 0, "R7 sext conflict");

    // R8: two drivers on a joined data bus; other bus write also dropped
    start(); d_join = 2'b11; d_src(2, LIT, 0, 16'h0001); d_src(0, LIT, 0, 16'h0002);
    d_to(0, 6); d_to(2, 6); a_src(0, LIT, 0, 16'h7777); a_to(0, 7);
    push(48'h0, 48'h0, 1, 0, "R8 join conflict");

    start(); a_src(0, REG, 7, 0); d_src(0, REG, 6, 0);
    push(48'h0, 48'h0, 0, 1, "R8 D7/D6 unchanged");
    start(); a_src(0, REG, 5, 0); d_src(2, REG, 6, 0);
    push(48'h0, 48'h0, 0, 1, "R8 D5/D6 high unchanged");

    // R10: user vs supervisor stack pointer
    start(); super_sel = 0; a_src(2, LIT, 0, 16'h0000); a_src(1, LIT, 0, 16'h1111); a_to(2, 15); a_to(1, 15);
    push({16'h0000, 16'h1111, 16'h0000}, 48'h0, 0, 1, "R10 write user SP");
    start(); super_sel = 1; a_src(2, LIT, 0, 16'h2222); a_src(1, LIT, 0, 16'h3333); a_to(2, 15); a_to(1, 15);
    push({16'h2222, 16'h3333, 16'h0000}, 48'h0, 0, 1, "R10 write supervisor SP");
    start(); super_sel = 0; a_src(2, REG, 15, 0); a_src(1, REG, 15, 0);
    push({16'h0000, 16'h1111, 16'h0000}, 48'h0, 0, 1, "R10 user SP readback");
    start(); super_sel = 1; a_src(2, REG, 15, 0); a_src(1, REG, 15, 0);
    push({16'h2222, 16'h3333, 16'h0000}, 48'h0, 0, 1, "R10 supervisor SP readback");

    // R11: step low changes nothing
    start(); super_sel = 0; d_src(0, LIT, 0, 16'h9999); d_to(0, 0);
    @(posedge clk); #2;
    check(abus_q == {16'h2222, 16'h3333, 16'h0000}, "R11 outputs hold", abus_q,
          {16'h2222, 16'h3333, 16'h0000});
    start(); a_src(2, REG, 0, 0); a_src(0, REG, 0, 0);
    push({16'h1234, 16'h0000, 16'h5678}, 48'h0, 0, 1, "R11 D0 unchanged");

    start();
    repeat (3) @(posedge clk);
    #2;
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule